// File: doc/BRIEF.md
# FP register-list transfer sequencer

This block moves a selected set of eight 96-bit floating-point registers to or from memory. Each selected register goes over a 32-bit request/acknowledge bus as three words. A command word sets the direction. It also says whether the 8-bit selection mask comes from the command itself or from the low byte of a general data register, which the block names through a select output. A separate mode input picks predecrement or postincrement addressing. The mode sets both the order in which registers are visited and whether the running address falls or rises.

The mask is scanned from its top bit down. In postincrement mode the top bit pairs with FP0 and the visit runs upward. In predecrement mode the top bit pairs with FP7 and the visit runs downward. The block drives the register-file port, the register index and the word select itself. It moves the data unchanged, with no conversion. When the run ends it reports the final address, so the address register can be written back. A bus fault stops the run at once.

Top module: `fpRegListMover`

## Requirements
- R1: Command bit 13 set moves registers to memory: memWrite is high on every beat, memWdata comes from rfRdata, and rfWe stays low. Bit 13 clear loads registers: memWrite is low, and each acknowledged beat writes memRdata into the register file through rfWe.
- R2: With command bit 11 set, the mask is dataRegVal[7:0], and dataRegSel equals command bits 6:4. With bit 11 clear, the mask is command bits 7:0 and dataRegVal has no effect.
- R3: In predecrement mode (preDec=1), mask bit 7-k selects register 7-k. Selected registers are visited in descending index order.
- R4: In postincrement mode (preDec=0), mask bit 7-k selects register k. Selected registers are visited in ascending index order.
- R5: Each register takes exactly three beats, with rfWordSel 0, 1 and 2 at addresses base, base+4 and base+8.
- R6: In predecrement mode, the running address drops by 12 before each register, and that lowered value is the register's base. finalAddr is the start address minus 12 times the register count.
- R7: In postincrement mode, the register's base is the running address, which then rises by 12. finalAddr is the start address plus 12 times the register count.
- R8: A beat with memFault high ends the run. done and fault pulse together on the next cycle, and no later request is made. The remaining registers and memory are untouched, and finalAddr is the running address from before the faulting register.
- R9: An empty mask pulses done on the cycle after start, with fault low, no bus request, and finalAddr equal to startAddr.
- R10: memReq, memAddr and the register index hold steady until the beat is acknowledged or faulted.
- R11: A start pulse while busy is ignored. The run in progress completes unchanged, and only one done pulse is produced.
- R12: After reset, busy, done, fault, memReq and rfWe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| cmdWord | input | 16 | Command: bit 13 direction, bit 11 dynamic mask, bits 6:4 data register, bits 7:0 static mask |
| dataRegSel | output | 3 | Data register index for a dynamic mask |
| dataRegVal | input | 32 | Selected data register value |
| startAddr | input | 32 | Initial running address |
| preDec | input | 1 | 1 predecrement, 0 postincrement |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | High with done when the run ended on a fault |
| finalAddr | output | 32 | Running address for write-back |
| memReq | output | 1 | Bus beat request |
| memWrite | output | 1 | Beat is a write |
| memAddr | output | 32 | Beat byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data |
| memAck | input | 1 | Beat completed |
| memFault | input | 1 | Beat faulted |
| rfIdx | output | 3 | Register being moved |
| rfWordSel | output | 2 | Word within the register |
| rfWe | output | 1 | Register-file write strobe |
| rfWdata | output | 32 | Register-file write data |
| rfRdata | input | 32 | Register-file read data |

## Verification
A corrupted mask shift or position counter shows up on the first beat after it happens, as a wrong rfIdx or a wrong visit order in the beat trace. A wrong word counter shows up within one register, as a fourth beat or a missing third beat, and also shifts every later address. An address error shows on the very next beat's memAddr and again in finalAddr at done. Control errors show at the bus: requests after a fault, a done that is late for an empty mask, or a second done after a start issued while busy.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int CMD_W       = 16;
  localparam int CMD_DIR_BIT = 13;
  localparam int CMD_DYN_BIT = 11;
  localparam int CMD_DSEL_LO = 4;
  localparam int CMD_DSEL_W  = 3;

  typedef struct packed {
    logic load;     // capture command, mask and address
    logic shift;    // advance the mask scan by one position
    logic wordInc;  // next word of the current register
    logic regDone;  // register finished: step address, clear word count
  } fpmStrobe_t;
endpackage

// File: rtl/fpmDatapath.sv
module fpmDatapath
  import fpm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int WORDS    = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  fpmStrobe_t                   stb,
  input  logic [CMD_W-1:0]             cmdWord,
  input  logic [DATA_W-1:0]            dataRegVal,
  input  logic [ADDR_W-1:0]            startAddr,
  input  logic                         preDec,
  output logic                         loadMaskZero,
  output logic                         mskEmpty,
  output logic                         mskTop,
  output logic                         lastWord,
  output logic                         dirStore,
  output logic [$clog2(NUM_REGS)-1:0]  regIdx,
  output logic [(WORDS>1 ? $clog2(WORDS) : 1)-1:0] wordSel,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [ADDR_W-1:0]            finalAddr
);
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int WSEL_W     = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORD_SHIFT = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] REG_STEP = ADDR_W'(WORDS * WORD_BYTES);

  logic [NUM_REGS-1:0] selMask, mskQ;
  logic [IDX_W-1:0]    posQ;
  logic [WSEL_W-1:0]   wselQ;
  logic [ADDR_W-1:0]   addrQ, baseAddr;
  logic                preDecQ, dirQ;

  wire unusedInputs = ^{cmdWord, dataRegVal};

  assign selMask      = cmdWord[CMD_DYN_BIT] ? dataRegVal[NUM_REGS-1:0] : cmdWord[NUM_REGS-1:0];
  assign loadMaskZero = (selMask == '0);
  assign mskEmpty     = (mskQ == '0);
  assign mskTop       = mskQ[NUM_REGS-1];
  assign lastWord     = (wselQ == WSEL_W'(WORDS - 1));
  assign dirStore     = dirQ;
  assign regIdx       = preDecQ ? (IDX_W'(NUM_REGS - 1) - posQ) : posQ;
  assign wordSel      = wselQ;
  assign baseAddr     = preDecQ ? (addrQ - REG_STEP) : addrQ;
  assign memAddr      = baseAddr + (ADDR_W'(wselQ) << WORD_SHIFT);
  assign finalAddr    = addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mskQ    <= '0;
      posQ    <= '0;
      wselQ   <= '0;
      addrQ   <= '0;
      preDecQ <= 1'b0;
      dirQ    <= 1'b0;
    end else if (stb.load) begin
      mskQ    <= selMask;
      posQ    <= '0;
      wselQ   <= '0;
      addrQ   <= startAddr;
      preDecQ <= preDec;
      dirQ    <= cmdWord[CMD_DIR_BIT];
    end else begin
      if (stb.shift) begin
        mskQ <= mskQ << 1;
        posQ <= posQ + 1'b1;
      end
      if (stb.regDone) begin
        wselQ <= '0;
        addrQ <= preDecQ ? (addrQ - REG_STEP) : (addrQ + REG_STEP);
      end else if (stb.wordInc) begin
        wselQ <= wselQ + 1'b1;
      end
    end
  end

  AST_WORD_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    stb.wordInc |-> !lastWord); // R5
endmodule

// File: rtl/fpmCtrl.sv
module fpmCtrl
  import fpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       loadMaskZero,
  input  logic       mskEmpty,
  input  logic       mskTop,
  input  logic       lastWord,
  input  logic       dirStore,
  input  logic       memAck,
  input  logic       memFault,
  output fpmStrobe_t stb,
  output logic       memReq,
  output logic       memWrite,
  output logic       rfWe,
  output logic       busy,
  output logic       done,
  output logic       fault
);
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_XFER} fpmState_e;

  fpmState_e stQ, stNxt;
  logic      finish, faultNxt, doneQ, faultQ;

  always_comb begin
    stb      = '0;
    stNxt    = stQ;
    finish   = 1'b0;
    faultNxt = 1'b0;
    case (stQ)
      ST_IDLE: if (start) begin
        stb.load = 1'b1;
        if (loadMaskZero) finish = 1'b1;
        else              stNxt  = ST_SCAN;
      end
      ST_SCAN: begin
        if (mskEmpty) begin
          finish = 1'b1;
          stNxt  = ST_IDLE;
        end else if (mskTop) begin
          stNxt = ST_XFER;
        end else begin
          stb.shift = 1'b1;
        end
      end
      ST_XFER: begin
        if (memFault) begin
          finish   = 1'b1;
          faultNxt = 1'b1;
          stNxt    = ST_IDLE;
        end else if (memAck) begin
          if (lastWord) begin
            stb.shift   = 1'b1;
            stb.regDone = 1'b1;
            stNxt       = ST_SCAN;
          end else begin
            stb.wordInc = 1'b1;
          end
        end
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ    <= ST_IDLE;
      doneQ  <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      stQ    <= stNxt;
      doneQ  <= finish;
      faultQ <= faultNxt;
    end
  end

  assign memReq   = (stQ == ST_XFER);
  assign memWrite = memReq & dirStore;
  assign rfWe     = memReq & memAck & ~memFault & ~dirStore;
  assign busy     = (stQ != ST_IDLE);
  assign done     = doneQ;
  assign fault    = faultQ;

  AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (done && !busy)); // R8
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start)); // R11
  AST_EMPTY_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && loadMaskZero) |=> (done && !busy && !memReq)); // R9
endmodule

// File: rtl/fpRegListMover.sv
module fpRegListMover
  import fpm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int WORDS    = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [CMD_W-1:0]            cmdWord,
  output logic [CMD_DSEL_W-1:0]       dataRegSel,
  input  logic [DATA_W-1:0]           dataRegVal,
  input  logic [ADDR_W-1:0]           startAddr,
  input  logic                        preDec,
  output logic                        busy,
  output logic                        done,
  output logic                        fault,
  output logic [ADDR_W-1:0]           finalAddr,
  output logic                        memReq,
  output logic                        memWrite,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [DATA_W-1:0]           memWdata,
  input  logic [DATA_W-1:0]           memRdata,
  input  logic                        memAck,
  input  logic                        memFault,
  output logic [$clog2(NUM_REGS)-1:0] rfIdx,
  output logic [(WORDS>1 ? $clog2(WORDS) : 1)-1:0] rfWordSel,
  output logic                        rfWe,
  output logic [DATA_W-1:0]           rfWdata,
  input  logic [DATA_W-1:0]           rfRdata
);
  fpmStrobe_t stb;
  logic loadMaskZero, mskEmpty, mskTop, lastWord, dirStore;

  assign dataRegSel = cmdWord[CMD_DSEL_LO +: CMD_DSEL_W];
  assign memWdata   = rfRdata;
  assign rfWdata    = memRdata;

  fpmCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .loadMaskZero(loadMaskZero), .mskEmpty(mskEmpty), .mskTop(mskTop),
    .lastWord(lastWord), .dirStore(dirStore),
    .memAck(memAck), .memFault(memFault),
    .stb(stb), .memReq(memReq), .memWrite(memWrite), .rfWe(rfWe),
    .busy(busy), .done(done), .fault(fault)
  );

  fpmDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .WORDS(WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cmdWord(cmdWord), .dataRegVal(dataRegVal), .startAddr(startAddr), .preDec(preDec),
    .loadMaskZero(loadMaskZero), .mskEmpty(mskEmpty), .mskTop(mskTop),
    .lastWord(lastWord), .dirStore(dirStore),
    .regIdx(rfIdx), .wordSel(rfWordSel), .memAddr(memAddr), .finalAddr(finalAddr)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !memFault) |=> (memReq && $stable(memAddr) && $stable(rfIdx))); // R10
  AST_STORE_NO_WE: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> !rfWe); // R1
endmodule

// File: tb/sim_fpRegListMover.sv
`timescale 1ns/1ps
module sim_fpRegListMover;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        start = 1'b0;
  logic [15:0] cmdWord = '0;
  logic [2:0]  dataRegSel;
  logic [31:0] dataRegVal = '0;
  logic [31:0] startAddr = '0;
  logic        preDec = 1'b0;
  logic        busy, done, fault;
  logic [31:0] finalAddr, memAddr, memWdata, rfWdata, rfRdata;
  logic [31:0] memRdata = '0;
  logic        memReq, memWrite, rfWe;
  logic        memAck = 1'b0, memFault = 1'b0;
  logic [2:0]  rfIdx;
  logic [1:0]  rfWordSel;

  fpRegListMover u0 (
    .clk(clk), .rstN(rstN), .start(start), .cmdWord(cmdWord), .dataRegSel(dataRegSel),
    .dataRegVal(dataRegVal), .startAddr(startAddr), .preDec(preDec),
    .busy(busy), .done(done), .fault(fault), .finalAddr(finalAddr),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .memFault(memFault),
    .rfIdx(rfIdx), .rfWordSel(rfWordSel), .rfWe(rfWe), .rfWdata(rfWdata), .rfRdata(rfRdata)
  );

  logic [31:0] fpr [8][3];
  logic [31:0] mem [256];
  logic [2:0]  trIdx [64];
  logic [1:0]  trWs [64];
  logic [31:0] trAd [64];
  logic        trWr [64];
  int trCnt = 0, reqCycles = 0, doneCnt = 0;
  int checks = 0, failures = 0;
  bit slowAck = 0, stallTog = 0, faultEn = 0, finished = 0;
  logic [31:0] faultAddr = '0;

  assign rfRdata = fpr[rfIdx][rfWordSel];

  // bus responder: decides ack/fault away from the active edge
  always @(negedge clk) begin
    memAck = 1'b0;
    memFault = 1'b0;
    if (memReq) begin
      if (faultEn && memAddr == faultAddr) memFault = 1'b1;
      else if (!slowAck || stallTog) memAck = 1'b1;
      stallTog = ~stallTog;
    end
    memRdata = mem[memAddr[9:2]];
  end

  // memory, register file and beat trace models
  always @(posedge clk) begin
    if (memReq) reqCycles <= reqCycles + 1;
    if (done) doneCnt <= doneCnt + 1;
    if (memReq && memAck && !memFault) begin
      trIdx[trCnt % 64] <= rfIdx;
      trWs[trCnt % 64]  <= rfWordSel;
      trAd[trCnt % 64]  <= memAddr;
      trWr[trCnt % 64]  <= memWrite;
      trCnt <= trCnt + 1;
      if (memWrite) mem[memAddr[9:2]] <= memWdata;
    end
    if (rfWe) fpr[rfIdx][rfWordSel] <= rfWdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fillModels();
    @(negedge clk);
    for (int r = 0; r < 8; r++)
      for (int w = 0; w < 3; w++) fpr[r][w] <= 32'hA000_0000 | (r << 8) | w;
    for (int i = 0; i < 256; i++) mem[i] <= 32'h5000_0000 + i;
    @(negedge clk);
  endtask

  task automatic launch(input logic [15:0] cmd, input logic [31:0] dv, input logic [31:0] sa,
                        input bit pd, output int cyc);
    @(negedge clk);
    cmdWord = cmd; dataRegVal = dv; startAddr = sa; preDec = pd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // expected beat trace from mask, mode and start address; maxRegs limits the count
  task automatic checkTrace(input string tag, input logic [7:0] msk, input bit pd,
                            input logic [31:0] sa, input int base, input int maxRegs, input bit wr);
    int n;
    n = 0;
    for (int k = 0; k < 8; k++) begin
      if (msk[7-k] && n < maxRegs) begin
        int r;
        logic [31:0] b;
        r = pd ? 7 - k : k;
        b = pd ? sa - 32'(12 * (n + 1)) : sa + 32'(12 * n);
        for (int w = 0; w < 3; w++) begin
          int e;
          e = (base + n * 3 + w) % 64;
          chk(trIdx[e] == 3'(r), {tag, " reg order"}, 32'(trIdx[e]), 32'(r));
          chk(trWs[e] == 2'(w), {tag, " R5 word"}, 32'(trWs[e]), 32'(w));
          chk(trAd[e] == b + 32'(4 * w), {tag, " addr"}, trAd[e], b + 32'(4 * w));
          chk(trWr[e] == wr, {tag, " R1 dir"}, 32'(trWr[e]), 32'(wr));
        end
        n++;
      end
    end
  endtask

  task automatic testReset();
    chk(!busy, "R12 busy", 32'(busy), 0);
    chk(!done, "R12 done", 32'(done), 0);
    chk(!fault, "R12 fault", 32'(fault), 0);
    chk(!memReq, "R12 memReq", 32'(memReq), 0);
    chk(!rfWe, "R12 rfWe", 32'(rfWe), 0);
  endtask

  task automatic testStorePost();
    int cyc, base;
    fillModels();
    base = trCnt;
    launch(16'h20A0, 32'h0000_00FF, 32'h100, 1'b0, cyc);
    chk(done && !fault, "R4 done", 32'(fault), 0);
    chk(trCnt - base == 6, "R5 beats", 32'(trCnt - base), 6);
    chk(finalAddr == 32'h118, "R7 finalAddr", finalAddr, 32'h118);
    checkTrace("R4 R2", 8'hA0, 1'b0, 32'h100, base, 8, 1'b1);
    chk(mem[32'h10C >> 2] == fpr[2][0], "R1 store data", mem[32'h10C >> 2], fpr[2][0]);
    chk(mem[32'h118 >> 2] == 32'h5000_0046, "R1 beyond run", mem[32'h118 >> 2], 32'h5000_0046);
  endtask

  task automatic testStorePre();
    int cyc, base;
    fillModels();
    base = trCnt;
    launch(16'h20A0, 32'h0, 32'h200, 1'b1, cyc);
    chk(trCnt - base == 6, "R3 beats", 32'(trCnt - base), 6);
    chk(finalAddr == 32'h1E8, "R6 finalAddr", finalAddr, 32'h1E8);
    checkTrace("R3 R6", 8'hA0, 1'b1, 32'h200, base, 8, 1'b1);
    chk(mem[32'h1F4 >> 2] == fpr[7][0], "R3 FP7 low word", mem[32'h1F4 >> 2], fpr[7][0]);
  endtask

  task automatic testLoadPre();
    int cyc, base;
    fillModels();
    base = trCnt;
    launch(16'h0003, 32'h0, 32'h300, 1'b1, cyc);
    chk(finalAddr == 32'h2E8, "R6 load finalAddr", finalAddr, 32'h2E8);
    checkTrace("R3 R1 load", 8'h03, 1'b1, 32'h300, base, 8, 1'b0);
    @(negedge clk);
    for (int w = 0; w < 3; w++) begin
      chk(fpr[1][w] == mem[(32'h2F4 + 32'(4 * w)) >> 2], "R1 load FP1", fpr[1][w], mem[(32'h2F4 + 32'(4 * w)) >> 2]);
      chk(fpr[0][w] == mem[(32'h2E8 + 32'(4 * w)) >> 2], "R1 load FP0", fpr[0][w], mem[(32'h2E8 + 32'(4 * w)) >> 2]);
    end
    chk(fpr[2][0] == 32'hA000_0200, "R1 unselected reg", fpr[2][0], 32'hA000_0200);
  endtask

  task automatic testDynamic();
    int cyc, base;
    fillModels();
    base = trCnt;
    @(negedge clk);
    cmdWord = 16'h2830;
    #1 chk(dataRegSel == 3'd3, "R2 dataRegSel", 32'(dataRegSel), 3);
    launch(16'h2830, 32'hFFFF_FF81, 32'h40, 1'b0, cyc);
    chk(trCnt - base == 6, "R2 dynamic beats", 32'(trCnt - base), 6);
    checkTrace("R2 dynamic", 8'h81, 1'b0, 32'h40, base, 8, 1'b1);
    chk(finalAddr == 32'h58, "R7 dynamic finalAddr", finalAddr, 32'h58);
  endtask

  task automatic testEmpty();
    int cyc, r0;
    r0 = reqCycles;
    launch(16'h2000, 32'h0000_00FF, 32'h80, 1'b0, cyc);
    chk(cyc == 1, "R9 one cycle", 32'(cyc), 1);
    chk(!fault, "R9 fault", 32'(fault), 0);
    chk(finalAddr == 32'h80, "R9 finalAddr", finalAddr, 32'h80);
    chk(reqCycles == r0, "R9 no request", 32'(reqCycles - r0), 0);
  endtask

  task automatic testFault();
    int cyc, base, r0;
    fillModels();
    faultEn = 1; faultAddr = 32'h194;
    base = trCnt;
    launch(16'h20E0, 32'h0, 32'h180, 1'b0, cyc);
    faultEn = 0;
    chk(fault === 1'b1, "R8 fault flag", 32'(fault), 1);
    chk(finalAddr == 32'h18C, "R8 finalAddr", finalAddr, 32'h18C);
    chk(trCnt - base == 5, "R8 beats", 32'(trCnt - base), 5);
    checkTrace("R8", 8'h80, 1'b0, 32'h180, base, 1, 1'b1);
    r0 = reqCycles;
    repeat (6) @(negedge clk);
    chk(reqCycles == r0, "R8 no later request", 32'(reqCycles - r0), 0);
    chk(mem[32'h194 >> 2] == 32'h5000_0065, "R8 faulted word", mem[32'h194 >> 2], 32'h5000_0065);
    chk(mem[32'h198 >> 2] == 32'h5000_0066, "R8 remaining reg", mem[32'h198 >> 2], 32'h5000_0066);
  endtask

  task automatic testSlow();
    int cyc, base;
    fillModels();
    slowAck = 1;
    base = trCnt;
    launch(16'h20FF, 32'h0, 32'h300, 1'b1, cyc);
    slowAck = 0;
    chk(trCnt - base == 24, "R10 beats", 32'(trCnt - base), 24);
    chk(cyc > 48, "R10 stalled run", 32'(cyc), 49);
    checkTrace("R10 R3", 8'hFF, 1'b1, 32'h300, base, 8, 1'b1);
    chk(finalAddr == 32'h2A0, "R6 slow finalAddr", finalAddr, 32'h2A0);
  endtask

  task automatic testStartBusy();
    int cyc, base, d0;
    fillModels();
    base = trCnt;
    d0 = doneCnt;
    @(negedge clk);
    cmdWord = 16'h2080; dataRegVal = '0; startAddr = 32'h20; preDec = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cmdWord = 16'h2001; startAddr = 32'h60; start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    chk(finalAddr == 32'h2C, "R11 finalAddr", finalAddr, 32'h2C);
    repeat (20) @(negedge clk);
    chk(doneCnt - d0 == 1, "R11 single done", 32'(doneCnt - d0), 1);
    chk(trCnt - base == 3, "R11 beats", 32'(trCnt - base), 3);
    checkTrace("R11", 8'h80, 1'b0, 32'h20, base, 8, 1'b1);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStorePost();
    testStorePre();
    testLoadPre();
    testDynamic();
    testEmpty();
    testFault();
    testSlow();
    testStartBusy();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule